// File: doc/BRIEF.md
# Call Progress Cadence Classifier

This block recognises telephone supervisory tones from timing alone. It receives a one-bit energy envelope, which is high while in-band energy is present, and a one-bit flag that is high while a DTMF digit is being detected. It measures how long each tone burst stays on and how long each gap stays off, in ticks of a fixed period taken from a prescaler on the system clock. It then matches the bursts against four cadences: line busy, reorder, audible ringing and steady (continuous) tone.

A result comes out as a 3-bit class code together with a one-cycle valid strobe. A periodic class is declared only after the same on/off cadence has been seen on two consecutive cycles. The envelope can also toggle on speech or on DTMF digits. For this reason, any envelope edge that happens while the DTMF flag is high is thrown away, together with all cadence history collected before it.

Top module: `cadence_classifier`

## Requirements
- R1: After synchronous active-low reset, `class_valid` is 0 and `class_code` is 0. Class codes are: 0 unknown, 1 continuous, 2 line busy, 3 reorder, 4 audible ringing. `class_code` changes only in a cycle where `class_valid` is 1.
- R2: A measured interval fits a class when it lies within ±TOL_PCT percent (default 20) of that class's nominal length. Lengths are counted in ticks of TICK_DIV clocks each.
- R3: A busy, reorder or ringing code is strobed only when an on interval followed by an off interval matches the same class as the cycle just before it. Every further matching cycle strobes the class again. A single matching cycle, or two adjacent cycles of different classes, produces no strobe.
- R4: Line busy is on about BUSY_TICKS (default 50 ticks, 0.5 s) and off about the same.
- R5: Reorder is on about REORDER_TICKS (default 25 ticks, 0.25 s) and off about the same.
- R6: Audible ringing is on about RING_ON_TICKS (default 200) and off about RING_OFF_TICKS (default 400).
- R7: Once the envelope has stayed high for CONT_TICKS (default 300) ticks without a break, code 1 is strobed once. The over-long on interval that ends later is ignored and gives no strobe.
- R8: An on interval that fits no class, or an on/off pair whose halves do not fit one common class, strobes code 0 and clears the match history.
- R9: An envelope edge while `dtmf_in` is high produces no strobe. It clears the match history and the interval in progress. The interval that began at a vetoed edge is discarded.
- R10: The interval counter saturates at its all-ones value and never wraps. An over-long gap therefore reads as no fit, not as a short one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| env_in | input | 1 | Energy envelope, high while tone energy is present (synchronous) |
| dtmf_in | input | 1 | High while a DTMF digit is detected (synchronous) |
| class_code | output | 3 | Last declared class (0 unknown, 1 continuous, 2 busy, 3 reorder, 4 ringing) |
| class_valid | output | 1 | One-cycle strobe marking a new declaration on `class_code` |

## Verification
Internal state in this block is only visible through the strobe that follows each envelope edge, so every kind of fault shows up one clock after the edge that ends an interval. If the match history is left stale, a strobe appears one cadence cycle too early. If it is cleared when it should not be, the expected strobe is missing. If the window bounds are off, a slightly short or slightly long cadence gives code 0 where it should give its class, or the reverse. If the counter wraps, the error only shows after a gap much longer than any window, when a false ringing strobe appears at the rising edge that ends that gap. The bench therefore drives complete cadences on tick boundaries and counts the strobes and the last code after each scenario.

// File: rtl/cpc_pkg.sv
// Shared types for the call progress cadence classifier.
package cpc_pkg;

    // Declared class codes, as seen on the class_code port.
    typedef enum logic [2:0] {
        CP_UNKNOWN    = 3'd0,
        CP_CONTINUOUS = 3'd1,
        CP_BUSY       = 3'd2,
        CP_REORDER    = 3'd3,
        CP_RINGING    = 3'd4
    } cp_class_e;

    // Which periodic classes accept one measured interval.
    typedef struct packed {
        logic busy;
        logic reorder;
        logic ring;
    } cp_fit_t;

endpackage

// File: rtl/cpc_tick_gen.sv
// Tick prescaler: emits a one-cycle tick every TICK_DIV clocks.
// Assumes TICK_DIV >= 2; the tick is the time base for all durations.
module cpc_tick_gen #(
    parameter int TICK_DIV = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_cnt;

    // Free-running divider that wraps after TICK_DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)                div_cnt <= '0;
        else if (div_cnt == DIV_LAST) div_cnt <= '0;
        else                       div_cnt <= div_cnt + 1'b1;
    end

    assign tick = (div_cnt == DIV_LAST);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);  // R2

endmodule

// File: rtl/cpc_interval_timer.sv
// Interval timer: detects envelope edges, measures the length of the level
// just finished in ticks (saturating), flags vetoed and stale edges, and
// raises a one-cycle hit when a steady high level reaches CONT_TICKS.
// Assumes env_in and dtmf_in are synchronous to clk.
module cpc_interval_timer #(
    parameter int CNT_W      = 9,
    parameter int CONT_TICKS = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             env_in,
    input  logic             dtmf_in,
    output logic [CNT_W-1:0] ivl_len,
    output logic             on_end,
    output logic             off_end,
    output logic             stale_end,
    output logic             veto,
    output logic             long_on,
    output logic             cont_hit
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CONT_LIM = CNT_W'(CONT_TICKS);

    logic             env_q;
    logic [CNT_W-1:0] run_cnt;
    logic             tainted;
    logic             cont_done;
    logic             edge_seen;

    assign edge_seen = env_in ^ env_q;
    assign veto      = edge_seen & dtmf_in;
    assign on_end    = edge_seen & !dtmf_in & !tainted &  env_q;
    assign off_end   = edge_seen & !dtmf_in & !tainted & !env_q;
    assign stale_end = edge_seen & !dtmf_in &  tainted;
    assign ivl_len   = run_cnt;
    assign long_on   = (run_cnt >= CONT_LIM);
    assign cont_hit  = env_q & !edge_seen & !tainted & !cont_done & long_on;

    // Level tracking, saturating duration count and taint of vetoed intervals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            env_q     <= 1'b0;
            run_cnt   <= '0;
            tainted   <= 1'b0;
            cont_done <= 1'b0;
        end else begin
            env_q <= env_in;
            if (edge_seen) begin
                run_cnt   <= '0;
                tainted   <= dtmf_in;
                cont_done <= 1'b0;
            end else begin
                if (tick && run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
                if (cont_hit) cont_done <= 1'b1;
            end
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == CNT_MAX && tick && !edge_seen) |=> (run_cnt == CNT_MAX));  // R10

endmodule

// File: rtl/cpc_window_match.sv
// Window match: reports which periodic classes accept one interval length,
// using +/-TOL_PCT percent around each nominal. RING_NOM selects the on or
// off nominal of ringing; busy and reorder are symmetric.
module cpc_window_match
    import cpc_pkg::*;
#(
    parameter int CNT_W         = 9,
    parameter int BUSY_TICKS    = 50,
    parameter int REORDER_TICKS = 25,
    parameter int RING_NOM      = 200,
    parameter int TOL_PCT       = 20
) (
    input  logic [CNT_W-1:0] ivl_len,
    output cp_fit_t          fit
);
    // True when v lies inside the tolerance window around nom.
    function automatic logic in_win(input int v, input int nom);
        return (v >= nom - (nom * TOL_PCT) / 100) &&
               (v <= nom + (nom * TOL_PCT) / 100);
    endfunction

    // Window comparisons for the three periodic classes.
    always_comb begin
        fit.busy    = in_win(int'(ivl_len), BUSY_TICKS);
        fit.reorder = in_win(int'(ivl_len), REORDER_TICKS);
        fit.ring    = in_win(int'(ivl_len), RING_NOM);
    end

endmodule

// File: rtl/cpc_tracker.sv
// Cadence tracker: pairs an on interval with the following off interval,
// keeps a two-deep match history and issues class declarations.
// Assumes the window sets of different classes do not overlap.
module cpc_tracker
    import cpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       veto,
    input  logic       cont_hit,
    input  logic       on_end,
    input  logic       off_end,
    input  logic       stale_end,
    input  logic       long_on,
    input  cp_fit_t    on_fit,
    input  cp_fit_t    off_fit,
    output logic [2:0] class_code,
    output logic       class_valid
);
    cp_class_e code_q;
    cp_class_e prev_cls;
    cp_class_e pair_cls;
    cp_fit_t   pend_fit;
    cp_fit_t   pair_fit;
    logic      pend_valid;
    logic [1:0] match_cnt;

    assign class_code = code_q;
    assign pair_fit   = pend_fit & off_fit;

    // Decode the common class of a completed on/off pair.
    always_comb begin
        if (pair_fit.busy)         pair_cls = CP_BUSY;
        else if (pair_fit.reorder) pair_cls = CP_REORDER;
        else if (pair_fit.ring)    pair_cls = CP_RINGING;
        else                       pair_cls = CP_UNKNOWN;
    end

    // History update and declaration strobe per interval event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q      <= CP_UNKNOWN;
            prev_cls    <= CP_UNKNOWN;
            pend_fit    <= '0;
            pend_valid  <= 1'b0;
            match_cnt   <= '0;
            class_valid <= 1'b0;
        end else begin
            class_valid <= 1'b0;
            if (veto) begin
                pend_valid <= 1'b0;
                match_cnt  <= '0;
            end else if (cont_hit) begin
                pend_valid  <= 1'b0;
                match_cnt   <= '0;
                code_q      <= CP_CONTINUOUS;
                class_valid <= 1'b1;
            end else if (on_end) begin
                if (long_on) begin
                    pend_valid <= 1'b0;
                end else if (on_fit == '0) begin
                    pend_valid  <= 1'b0;
                    match_cnt   <= '0;
                    code_q      <= CP_UNKNOWN;
                    class_valid <= 1'b1;
                end else begin
                    pend_valid <= 1'b1;
                    pend_fit   <= on_fit;
                end
            end else if (off_end) begin
                pend_valid <= 1'b0;
                if (pend_valid) begin
                    if (pair_cls == CP_UNKNOWN) begin
                        match_cnt   <= '0;
                        code_q      <= CP_UNKNOWN;
                        class_valid <= 1'b1;
                    end else if (pair_cls == prev_cls && match_cnt != 2'd0) begin
                        match_cnt   <= 2'd2;
                        code_q      <= pair_cls;
                        class_valid <= 1'b1;
                    end else begin
                        prev_cls  <= pair_cls;
                        match_cnt <= 2'd1;
                    end
                end
            end else if (stale_end) begin
                pend_valid <= 1'b0;
            end
        end
    end

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !class_valid |-> $stable(class_code));  // R1
    AST_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        (class_valid && code_q inside {CP_BUSY, CP_REORDER, CP_RINGING}) |-> (match_cnt == 2'd2));  // R3
    AST_UNKNOWN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (class_valid && code_q == CP_UNKNOWN) |-> (match_cnt == 2'd0 && !pend_valid));  // R8
    AST_VETO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        veto |=> (!class_valid && match_cnt == 2'd0));  // R9

endmodule

// File: rtl/cadence_classifier.sv
// Call progress cadence classifier top: prescaler, interval timer, one window
// matcher per phase (on, off) and the cadence tracker. Nominal durations are
// in ticks; the counter is sized so its saturated value lies above every window.
module cadence_classifier
    import cpc_pkg::*;
#(
    parameter int TICK_DIV       = 100000,
    parameter int BUSY_TICKS     = 50,
    parameter int REORDER_TICKS  = 25,
    parameter int RING_ON_TICKS  = 200,
    parameter int RING_OFF_TICKS = 400,
    parameter int CONT_TICKS     = 300,
    parameter int TOL_PCT        = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       env_in,
    input  logic       dtmf_in,
    output logic [2:0] class_code,
    output logic       class_valid
);
    localparam int RING_OFF_HI = RING_OFF_TICKS + (RING_OFF_TICKS * TOL_PCT) / 100;
    localparam int NEED_MAX    = (RING_OFF_HI > CONT_TICKS) ? RING_OFF_HI : CONT_TICKS;
    localparam int CNT_W       = $clog2(NEED_MAX + 2);

    logic             tick;
    logic [CNT_W-1:0] ivl_len;
    logic             on_end, off_end, stale_end, veto, long_on, cont_hit;
    cp_fit_t          phase_fit [2];

    cpc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    cpc_interval_timer #(.CNT_W(CNT_W), .CONT_TICKS(CONT_TICKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .env_in    (env_in),
        .dtmf_in   (dtmf_in),
        .ivl_len   (ivl_len),
        .on_end    (on_end),
        .off_end   (off_end),
        .stale_end (stale_end),
        .veto      (veto),
        .long_on   (long_on),
        .cont_hit  (cont_hit)
    );

    // Phase 0 judges on intervals, phase 1 judges off intervals.
    for (genvar p = 0; p < 2; p++) begin : g_phase
        cpc_window_match #(
            .CNT_W         (CNT_W),
            .BUSY_TICKS    (BUSY_TICKS),
            .REORDER_TICKS (REORDER_TICKS),
            .RING_NOM      ((p == 0) ? RING_ON_TICKS : RING_OFF_TICKS),
            .TOL_PCT       (TOL_PCT)
        ) u_win (
            .ivl_len (ivl_len),
            .fit     (phase_fit[p])
        );
    end

    cpc_tracker u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .veto        (veto),
        .cont_hit    (cont_hit),
        .on_end      (on_end),
        .off_end     (off_end),
        .stale_end   (stale_end),
        .long_on     (long_on),
        .on_fit      (phase_fit[0]),
        .off_fit     (phase_fit[1]),
        .class_code  (class_code),
        .class_valid (class_valid)
    );

endmodule

// File: tb/tb_cadence_classifier.sv
// Directed bench: one task per scenario, each checking strobe count and code.
module tb_cadence_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 4;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       env_in = 1'b0;
    logic       dtmf_in = 1'b0;
    logic [2:0] class_code;
    logic       class_valid;

    int n_checks = 0;
    int n_errors = 0;
    int n_strobe = 0;
    int last_code = 0;

    cadence_classifier #(.TICK_DIV(TDIV)) dut (
        .clk(clk), .rst_n(rst_n), .env_in(env_in), .dtmf_in(dtmf_in),
        .class_code(class_code), .class_valid(class_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Strobe monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n && class_valid) begin
            n_strobe  = n_strobe + 1;
            last_code = int'(class_code);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; env_in = 1'b0; dtmf_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_strobe = 0; last_code = 0;
        repeat (2 * TDIV) @(negedge clk);
    endtask

    task automatic hold(input logic lvl, input int ticks);
        env_in = lvl;
        repeat (ticks * TDIV) @(negedge clk);
    endtask

    // n on/off cycles, then a closing on burst and a quiet tail.
    task automatic cadence(input int on_t, input int off_t, input int n);
        for (int i = 0; i < n; i++) begin
            hold(1'b1, on_t);
            hold(1'b0, off_t);
        end
        hold(1'b1, on_t);
        hold(1'b0, 10);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 valid after reset", int'(class_valid), 0);
        chk("R1 code after reset", int'(class_code), 0);
    endtask

    task automatic t_busy();
        do_reset(); cadence(50, 50, 2);
        chk("R4 busy strobes", n_strobe, 1);
        chk("R4 busy code", last_code, 2);
    endtask

    task automatic t_reorder();
        do_reset(); cadence(25, 25, 2);
        chk("R5 reorder strobes", n_strobe, 1);
        chk("R5 reorder code", last_code, 3);
    endtask

    task automatic t_ringing();
        do_reset(); cadence(200, 400, 2);
        chk("R6 ringing strobes", n_strobe, 1);
        chk("R6 ringing code", last_code, 4);
    endtask

    task automatic t_single_and_mixed();
        do_reset(); cadence(50, 50, 1);
        chk("R3 single cycle no strobe", n_strobe, 0);
        do_reset();
        hold(1'b1, 50); hold(1'b0, 50);
        cadence(25, 25, 1);
        chk("R3 mixed classes no strobe", n_strobe, 0);
        do_reset(); cadence(25, 25, 3);
        chk("R3 third cycle strobes again", n_strobe, 2);
    endtask

    task automatic t_continuous();
        do_reset();
        hold(1'b1, 320);
        chk("R7 continuous strobe", n_strobe, 1);
        chk("R7 continuous code", last_code, 1);
        hold(1'b0, 20);
        chk("R7 long on ignored", n_strobe, 1);
    endtask

    task automatic t_mismatch();
        do_reset();
        hold(1'b1, 50); hold(1'b0, 25); hold(1'b1, 5);
        chk("R8 mismatch strobe", n_strobe, 1);
        chk("R8 mismatch code", last_code, 0);
        do_reset();
        hold(1'b1, 50); hold(1'b0, 25);
        cadence(50, 50, 2);
        chk("R8 recovery strobes", n_strobe, 2);
        chk("R8 recovery code", last_code, 2);
    endtask

    task automatic t_tolerance();
        do_reset(); cadence(42, 58, 2);
        chk("R2 inside window strobes", n_strobe, 1);
        chk("R2 inside window code", last_code, 2);
        do_reset(); hold(1'b1, 35); hold(1'b0, 10);
        chk("R2 short on strobe", n_strobe, 1);
        chk("R2 short on code", last_code, 0);
        do_reset(); hold(1'b1, 66); hold(1'b0, 10);
        chk("R2 long on strobe", n_strobe, 1);
        chk("R2 long on code", last_code, 0);
    endtask

    task automatic t_veto();
        do_reset();
        dtmf_in = 1'b1;
        cadence(50, 50, 3);
        dtmf_in = 1'b0;
        chk("R9 vetoed edges no strobe", n_strobe, 0);
        cadence(50, 50, 2);
        chk("R9 recovery strobes", n_strobe, 1);
        chk("R9 recovery code", last_code, 2);
    endtask

    task automatic t_saturate();
        do_reset();
        hold(1'b1, 200); hold(1'b0, 400);
        hold(1'b1, 200); hold(1'b0, 912);
        hold(1'b1, 20);
        chk("R10 long gap strobes", n_strobe, 1);
        chk("R10 long gap code", last_code, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_busy();
                t_reorder();
                t_ringing();
                t_single_and_mixed();
                t_continuous();
                t_mismatch();
                t_tolerance();
                t_veto();
                t_saturate();
            end
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule